// File: doc/BRIEF.md
# Write-Only Serial Configuration Target

This block is an I2C target that lets a bus controller set six small configuration fields. The controller sends a START, the 7-bit target address 1001101 with the R/W bit, one command byte, and then a STOP. The three upper bits of the command byte select a field. The five lower bits are its new value. The command byte is held in a staging register and is copied into the selected field only when the closing STOP is seen. A half-finished or abandoned frame therefore never alters the outputs.

SCL and SDA are brought into the system clock domain through a synchroniser and then edge-detected. The block only pulls SDA low, and only while it acknowledges. A read request to the matching address is acknowledged, and the line is then left released, so the controller reads all ones. All six fields are presented in parallel on one output bus, with field k on bits [5k+4:5k]. On reset, each field loads a parameter default. With the default parameters, fields 0 to 5 reset to 0x00, 0x1F, 0x0C, 0x0C, 0x02 and 0x10.

Top module: `cfg_i2c_target`

## Requirements
- R1: During and after a synchronous active-low reset, every field equals its parameter default and the staging register is empty.
- R2: The pull-down output is inactive except while the block acknowledges. An idle bus and every data bit sent toward the controller read as 1.
- R3: The block acknowledges an address byte of 0x9A and the command byte that follows it. It does this by pulling SDA low for the whole 9th SCL pulse.
- R4: A received command byte has no effect on the outputs until the following valid STOP. At that STOP, field B7..B5 takes the value B4..B0.
- R5: An address byte of 0x9B is acknowledged. After that the block leaves SDA released, so a following read returns 0xFF and no field changes.
- R6: When the address does not match, the block gives no acknowledge and ignores every later byte until the next START or STOP.
- R7: Command bytes with select code 110 or 111 are acknowledged, but at the STOP they change no field.
- R8: A STOP that arrives before an acknowledged command byte, including one in the middle of a byte, leaves every field unchanged.
- R9: A repeated START discards any staged command and restarts address reception.
- R10: A STOP that falls in the same SCL-high interval as a START is ignored. After it, the block keeps receiving an address byte.
- R11: Bytes after the command byte in the same frame get no acknowledge. The staged command is still committed at the STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable), 0 = released |
| cfg_regs_o | output | 30 | All six 5-bit fields; field k on bits [5k+4:5k] |

## Verification
START and STOP detection can both occur inside a single SCL-high interval, and the qualifier that suppresses the STOP must judge them against each other. The bench provokes this case directly. It stages a command, then raises SCL and drives SDA down and back up before SCL falls again. It then clocks an address byte with no further START. The case is judged at the ports: that address byte must be acknowledged, the staged command must have been discarded, and the command of the continued frame must be the one that is committed at the final STOP.

// File: rtl/cfg_i2c_pkg.sv
// Shared constants and the receive state type for the serial configuration target.
package cfg_i2c_pkg;
    localparam int BYTE_W     = 8;
    localparam int DEV_ADDR_W = 7;

    typedef enum logic [2:0] {
        RX_IDLE,      // waiting for START
        RX_ADDR,      // shifting in the address byte
        RX_ADDR_ACK,  // driving the address acknowledge
        RX_CMD,       // shifting in the command byte
        RX_CMD_ACK,   // driving the command acknowledge
        RX_HOLD       // command staged, later bytes ignored until STOP/START
    } rx_state_t;
endpackage

// File: rtl/cfg_i2c_bus_mon.sv
// Synchronises SCL and SDA into clk and derives bus events.
// Assumes the bus is idle-high at reset and much slower than clk.
// A STOP is suppressed when a START occurred earlier in the same SCL-high interval.
module cfg_i2c_bus_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ok,
    output logic stop_ok
);
    localparam int LINES = 2;  // index 0 = SCL, 1 = SDA

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;
    logic             start_seen_high;
    logic             start_raw;
    logic             stop_raw;

    assign raw_lines = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [SYNC_STAGES-1:0] chain;
            // Purpose: metastability chain for one bus line, idle-high in reset.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[SYNC_STAGES-2:0], raw_lines[g]};
            end
            assign synced[g] = chain[SYNC_STAGES-1];
        end
    endgenerate

    // Purpose: one-cycle history of the synchronised lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= synced;
    end

    assign scl_s     = synced[0];
    assign sda_s     = synced[1];
    assign scl_rise  = synced[0] & ~prev[0];
    assign scl_fall  = ~synced[0] & prev[0];
    assign start_raw = synced[0] & prev[0] & prev[1] & ~synced[1];
    assign stop_raw  = synced[0] & prev[0] & ~prev[1] & synced[1];

    // Purpose: remember a START until SCL next falls, to veto a STOP in the same high.
    always_ff @(posedge clk) begin
        if (!rst_n)         start_seen_high <= 1'b0;
        else if (scl_fall)  start_seen_high <= 1'b0;
        else if (start_raw) start_seen_high <= 1'b1;
    end

    assign start_ok = start_raw;
    assign stop_ok  = stop_raw & ~start_seen_high;
endmodule

// File: rtl/cfg_i2c_rx.sv
// Byte receiver and acknowledge sequencer for a write-only target.
// Shifts bits on SCL rise, changes the pull-down only after SCL falls,
// stages one command byte per frame and requests a commit on a valid STOP.
module cfg_i2c_rx
    import cfg_i2c_pkg::*;
#(
    parameter logic [DEV_ADDR_W-1:0] DEV_ADDR = 7'h4D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_ok,
    input  logic              stop_ok,
    output logic              sda_pull,
    output logic              commit,
    output logic [BYTE_W-1:0] staged
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    rx_state_t         state;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              rw_q;
    logic              staged_valid;
    logic              byte_done;

    assign byte_done = (bitcnt == CNT_W'(BYTE_W));

    // Purpose: frame sequencing, bit shifting, acknowledge drive and commit request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= RX_IDLE;
            shreg        <= '0;
            bitcnt       <= '0;
            rw_q         <= 1'b0;
            staged       <= '0;
            staged_valid <= 1'b0;
            sda_pull     <= 1'b0;
            commit       <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (start_ok) begin
                state        <= RX_ADDR;
                bitcnt       <= '0;
                staged_valid <= 1'b0;
                sda_pull     <= 1'b0;
            end else if (stop_ok) begin
                commit       <= staged_valid;
                staged_valid <= 1'b0;
                state        <= RX_IDLE;
                sda_pull     <= 1'b0;
            end else begin
                case (state)
                    RX_ADDR, RX_CMD: begin
                        if (scl_rise && !byte_done) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && byte_done) begin
                            if (state == RX_ADDR) begin
                                if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                    sda_pull <= 1'b1;
                                    rw_q     <= shreg[0];
                                    state    <= RX_ADDR_ACK;
                                end else begin
                                    state <= RX_IDLE;
                                end
                            end else begin
                                sda_pull     <= 1'b1;
                                staged       <= shreg;
                                staged_valid <= 1'b1;
                                state        <= RX_CMD_ACK;
                            end
                        end
                    end
                    RX_ADDR_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            bitcnt   <= '0;
                            state    <= rw_q ? RX_IDLE : RX_CMD;
                        end
                    end
                    RX_CMD_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            state    <= RX_HOLD;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfg_i2c_regbank.sv
// Bank of configuration fields with parameter reset values.
// Assumes commit is a single-cycle pulse; select codes beyond the bank match nothing.
module cfg_i2c_regbank #(
    parameter int                           NUM_REGS = 6,
    parameter int                           FIELD_W  = 5,
    parameter int                           SEL_W    = 3,
    parameter logic [NUM_REGS*FIELD_W-1:0]  DEFAULTS = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  logic [SEL_W+FIELD_W-1:0]      cmd,
    output logic [NUM_REGS*FIELD_W-1:0]   regs_o
);
    logic [SEL_W-1:0] sel;
    assign sel = cmd[SEL_W+FIELD_W-1:FIELD_W];

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_field
            // Purpose: load default in reset, take the payload when this field is selected.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_o[r*FIELD_W +: FIELD_W] <= DEFAULTS[r*FIELD_W +: FIELD_W];
                else if (commit && (sel == SEL_W'(r)))
                    regs_o[r*FIELD_W +: FIELD_W] <= cmd[FIELD_W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/cfg_i2c_target.sv
// Write-only serial configuration target: bus monitor, receiver and field bank.
// Assumes an external pull-up on SDA; sda_pull_o enables the open-drain low drive.
module cfg_i2c_target
    import cfg_i2c_pkg::*;
#(
    parameter logic [DEV_ADDR_W-1:0]        DEV_ADDR    = 7'h4D,
    parameter int                           NUM_REGS    = 6,
    parameter int                           FIELD_W     = 5,
    parameter int                           SYNC_STAGES = 2,
    parameter logic [NUM_REGS*FIELD_W-1:0]  DEFAULTS    =
        {5'h10, 5'h02, 5'h0C, 5'h0C, 5'h1F, 5'h00}
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scl_i,
    input  logic                        sda_i,
    output logic                        sda_pull_o,
    output logic [NUM_REGS*FIELD_W-1:0] cfg_regs_o
);
    localparam int SEL_W = BYTE_W - FIELD_W;

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_ok;
    logic              stop_ok;
    logic              commit;
    logic [BYTE_W-1:0] staged;

    cfg_i2c_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ok (start_ok),
        .stop_ok  (stop_ok)
    );

    cfg_i2c_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_s    (sda_s),
        .start_ok (start_ok),
        .stop_ok  (stop_ok),
        .sda_pull (sda_pull_o),
        .commit   (commit),
        .staged   (staged)
    );

    cfg_i2c_regbank #(
        .NUM_REGS (NUM_REGS),
        .FIELD_W  (FIELD_W),
        .SEL_W    (SEL_W),
        .DEFAULTS (DEFAULTS)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .cmd    (staged),
        .regs_o (cfg_regs_o)
    );
endmodule

// File: rtl/cfg_i2c_target_chk.sv
// Temporal checks on the configuration target, bound into every instance.
module cfg_i2c_target_chk #(
    parameter int                          NUM_REGS = 6,
    parameter int                          FIELD_W  = 5,
    parameter logic [NUM_REGS*FIELD_W-1:0] DEFAULTS = '0
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        scl_s,
    input logic                        stop_ok,
    input logic                        commit,
    input logic                        sda_pull_o,
    input logic [NUM_REGS*FIELD_W-1:0] cfg_regs_o
);
    AST_RESET_DEFAULTS: assert property (@(posedge clk)
        !rst_n |=> (cfg_regs_o == DEFAULTS));                                              // R1
    AST_PULL_EDGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_pull_o) || $fell(sda_pull_o)) |-> !scl_s);                              // R3
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ok |=> !sda_pull_o);                                                          // R2
    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cfg_regs_o));                                                  // R4
    AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(stop_ok));                                                        // R4
endmodule

bind cfg_i2c_target cfg_i2c_target_chk #(
    .NUM_REGS (NUM_REGS),
    .FIELD_W  (FIELD_W),
    .DEFAULTS (DEFAULTS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .stop_ok    (stop_ok),
    .commit     (commit),
    .sda_pull_o (sda_pull_o),
    .cfg_regs_o (cfg_regs_o)
);

// File: tb/cfg_i2c_target_bench.sv
// Scoreboard bench: frame tasks push expected field snapshots, a monitor compares them.
module cfg_i2c_target_bench;
    localparam int Q    = 8;   // clocks per quarter SCL period
    localparam int REGW = 30;
    localparam logic [REGW-1:0] DEF = {5'h10, 5'h02, 5'h0C, 5'h0C, 5'h1F, 5'h00};

    typedef struct {
        logic [REGW-1:0] exp;
        string           tag;
    } sb_item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            scl_m = 1'b1;
    logic            sda_m = 1'b1;
    logic            sda_pull;
    logic [REGW-1:0] regs;
    logic            sda_bus;
    logic [REGW-1:0] model = DEF;
    sb_item_t        sb_q[$];
    int              checks = 0;
    int              errors = 0;

    assign sda_bus = sda_m & ~sda_pull;

    always #4 clk = ~clk;  // 125 MHz

    cfg_i2c_target u_cfg_i2c_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_pull_o (sda_pull),
        .cfg_regs_o (regs)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_q(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic expect_regs(input logic [REGW-1:0] v, input string tag);
        sb_item_t it;
        repeat (8) @(negedge clk);
        it.exp = v;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: pop one expected snapshot per cycle and compare with the outputs.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                chk(regs == it.exp, it.tag, 32'(regs), 32'(it.exp));
            end
        end
    end

    function automatic logic [REGW-1:0] apply(input logic [REGW-1:0] m, input logic [7:0] c);
        logic [REGW-1:0] r;
        r = m;
        if (c[7:5] < 3'd6) r[c[7:5]*5 +: 5] = c[4:0];
        return r;
    endfunction

    task automatic bus_start;
        sda_m = 1'b1; wait_q; scl_m = 1'b1; wait_q; sda_m = 1'b0; wait_q; scl_m = 1'b0; wait_q;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wait_q; scl_m = 1'b1; wait_q; sda_m = 1'b1; wait_q(2);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wait_q; scl_m = 1'b1; wait_q(2); scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        sda_m = 1'b1; wait_q; scl_m = 1'b1; wait_q;
        acked = ~sda_bus;
        wait_q; scl_m = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q; scl_m = 1'b1; wait_q; b[i] = sda_bus; wait_q; scl_m = 1'b0;
        end
        wait_q; scl_m = 1'b1; wait_q(2); scl_m = 1'b0;  // controller NACK
    endtask

    // Full write frame with acknowledge checks and scoreboard update.
    task automatic write_frame(input logic [7:0] c, input string tag);
        logic a;
        bus_start;
        send_byte(8'h9A, a); chk(a, {tag, " R3 addr ack"}, 32'(a), 1);
        send_byte(c, a);     chk(a, {tag, " R3 cmd ack"}, 32'(a), 1);
        expect_regs(model, {tag, " R4 staged not visible"});
        bus_stop;
        model = apply(model, c);
        expect_regs(model, {tag, " R4 commit"});
    endtask

    initial begin
        logic       a;
        logic [7:0] rb;
        logic [7:0] wcmds [5];
        wcmds = '{8'h35, 8'h47, 8'h7E, 8'h99, 8'hA3};

        repeat (10) @(negedge clk);
        expect_regs(DEF, "R1 reset defaults");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(sda_bus == 1'b1, "R2 idle line released", 32'(sda_bus), 1);

        write_frame(8'h0B, "field0");
        foreach (wcmds[i]) write_frame(wcmds[i], "fieldN");

        // R7: select codes 110 and 111
        write_frame(8'hC5, "R7 code6");
        write_frame(8'hFF, "R7 code7");

        // R6: wrong address
        bus_start;
        send_byte(8'h98, a); chk(!a, "R6 no ack on wrong addr", 32'(a), 0);
        send_byte(8'h0A, a); chk(!a, "R6 later byte ignored", 32'(a), 0);
        bus_stop;
        expect_regs(model, "R6 fields unchanged");

        // R5: read request
        bus_start;
        send_byte(8'h9B, a); chk(a, "R5 read addr ack", 32'(a), 1);
        read_byte(rb);       chk(rb == 8'hFF, "R5 reads all ones", 32'(rb), 32'hFF);
        bus_stop;
        expect_regs(model, "R5 fields unchanged");

        // R8: STOP mid-command and STOP right after the address
        bus_start;
        send_byte(8'h9A, a);
        send_bits(8'h1F, 4);
        bus_stop;
        expect_regs(model, "R8 mid-byte stop");
        bus_start;
        send_byte(8'h9A, a);
        bus_stop;
        expect_regs(model, "R8 stop after addr");

        // R9: repeated START discards staged byte
        bus_start;
        send_byte(8'h9A, a);
        send_byte(8'h01, a);
        bus_start;
        send_byte(8'h9A, a); chk(a, "R9 addr ack after repeated start", 32'(a), 1);
        send_byte(8'h22, a);
        bus_stop;
        model = apply(model, 8'h22);
        expect_regs(model, "R9 only second command kept");
        bus_start;
        send_byte(8'h9A, a);
        send_byte(8'h04, a);
        bus_start;
        bus_stop;
        expect_regs(model, "R9 staged dropped by repeated start");

        // R10: START and STOP in one SCL-high interval
        bus_start;
        send_byte(8'h9A, a);
        send_byte(8'h1D, a);
        sda_m = 1'b1; wait_q; scl_m = 1'b1; wait_q;
        sda_m = 1'b0; wait_q; sda_m = 1'b1; wait_q;
        scl_m = 1'b0; wait_q;
        send_byte(8'h9A, a); chk(a, "R10 stop ignored, addr still received", 32'(a), 1);
        send_byte(8'h2A, a); chk(a, "R10 cmd ack", 32'(a), 1);
        bus_stop;
        model = apply(model, 8'h2A);
        expect_regs(model, "R10 first command discarded");

        // R11: extra byte in a frame
        bus_start;
        send_byte(8'h9A, a);
        send_byte(8'h48, a);
        send_byte(8'h6F, a); chk(!a, "R11 extra byte not acked", 32'(a), 0);
        bus_stop;
        model = apply(model, 8'h48);
        expect_regs(model, "R11 first command committed");

        while (sb_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule